// File: doc/BRIEF.md
# Closed-Loop Fan Speed Controller

This block keeps a fan turning at a speed chosen by the host. The host writes a target tachometer count: the number of 32.768 kHz timebase ticks expected between two rising edges of the fan's tach signal. A larger count means a slower fan. The block measures the real count continuously. At a programmable update interval it moves an 8-bit drive code toward the target. Each move is limited by a step register and bounded below by a minimum-drive register and above by 255.

When the loop starts, the block first runs a timed spin-up. The fan gets full drive for the first quarter of the spin-up time and a fixed holding level for the rest. At the end of spin-up the block checks the measured count against a validity threshold. If the fan has not come up to speed, it flags a spin failure and starts the spin-up again.

A fan that produces no tach edge for a full count window is reported as stalled. In the closed loop, a stall triggers a fresh spin-up at the next update. With the loop disabled, the drive simply follows a host-written code. Out of reset the drive holds a level picked by a strap input until the host first writes the configuration or the target.

Top module: `fan_speed_ctl`

## Requirements
- R1: After reset the drive equals the strap level for `boot_sel` (00 gives 0, 01 gives 128, 10 gives 191, 11 gives 255). It stays there until the host writes register 0 (configuration) or register 5 (target). Writes to other registers do not release it.
- R2: When configuration bit 0 (loop enable) is 0, the drive follows register 1 (manual drive code). Register 7 reads back {spin_fail at bit 9, stalled at bit 8, drive at bits 7:0}.
- R3: Register 6 returns the number of `tick_32k` ticks counted between the two most recent rising edges of `tach_in`.
- R4: If `tach_in` shows no rising edge for 2^CNT_W-1 ticks, the count saturates at all ones and `stalled` is high. The count also starts at all ones after reset.
- R5: Spin-up holds drive 255 for one quarter of the spin-up time, then holds the level selected by configuration bit 6 (0 gives 153, 1 gives 191) for the remainder. Configuration bits 5:4 select 250, 500, 1000 or 2000 ms. Each ms lasts TICKS_PER_MS ticks.
- R6: At the end of spin-up, if the count is above register 4 (validity threshold), `spin_fail` goes high and spin-up restarts at full drive. Otherwise `spin_fail` goes low and the loop runs, starting from the holding level.
- R7: In the loop, drive updates occur every N ms. Configuration bits 3:1 select N: 0 gives 100, 1 gives 200, 2 gives 300, 3 gives 500, 4 gives 800, 5 gives 1200, and 6 or 7 give 1600.
- R8: At an update, a count above register 5 (target) raises the drive by register 2 (step), clamped at 255. A count below the target lowers the drive by the step. An equal count leaves the drive unchanged.
- R9: While the loop runs, the drive is never below register 3 (minimum drive). A lowering step stops at that floor.
- R10: An update that finds the fan stalled restarts the spin-up routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| tach_in | input | 1 | Fan tachometer, asynchronous |
| boot_sel | input | 2 | Strap selecting the drive held out of reset |
| drive | output | 8 | Drive code to the fan DAC |
| stalled | output | 1 | Tach count saturated |
| spin_fail | output | 1 | Last spin-up ended without a valid count |

## Verification
The hardest case to reach is a failed spin-up followed by a successful retry. The loop must be running, the tach must go silent long enough for the counter to saturate, and an update must then see the stall. Only after that does the failed check at the end of the holding phase occur. The bench gets there by first driving the loop to its floor against a high target, so that the jump to full drive stands out. It then stops the tach generator, times each phase of the repeated spin-up from the drive changes, and restarts the tach during the retry's full-drive phase so that the next check passes.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;

  typedef enum logic [2:0] {
    FS_BOOT,
    FS_MANUAL,
    FS_SPIN_FULL,
    FS_SPIN_HOLD,
    FS_RUN
  } fan_state_e;

  typedef struct packed {
    logic       hold_hi;
    logic [1:0] spin_sel;
    logic [2:0] upd_sel;
    logic       en;
  } fan_cfg_t;

  localparam logic [2:0] A_CFG    = 3'd0;
  localparam logic [2:0] A_MANUAL = 3'd1;
  localparam logic [2:0] A_STEP   = 3'd2;
  localparam logic [2:0] A_FLOOR  = 3'd3;
  localparam logic [2:0] A_VALID  = 3'd4;
  localparam logic [2:0] A_TARGET = 3'd5;
  localparam logic [2:0] A_MEAS   = 3'd6;
  localparam logic [2:0] A_STAT   = 3'd7;

  localparam logic [6:0] CFG_RESET = 7'h17;

  function automatic logic [11:0] fc_update_ms(input logic [2:0] sel);
    case (sel)
      3'd0:    return 12'd100;
      3'd1:    return 12'd200;
      3'd2:    return 12'd300;
      3'd3:    return 12'd500;
      3'd4:    return 12'd800;
      3'd5:    return 12'd1200;
      default: return 12'd1600;
    endcase
  endfunction

  function automatic logic [11:0] fc_spin_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 12'd250;
      2'd1:    return 12'd500;
      2'd2:    return 12'd1000;
      default: return 12'd2000;
    endcase
  endfunction

  function automatic logic [7:0] fc_boot_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd0;
      2'd1:    return 8'd128;
      2'd2:    return 8'd191;
      default: return 8'd255;
    endcase
  endfunction

  function automatic logic [7:0] fc_hold_level(input logic hi);
    return hi ? 8'd191 : 8'd153;
  endfunction

  function automatic logic [7:0] fc_raise(input logic [7:0] d, input logic [7:0] step);
    logic [8:0] s;
    s = {1'b0, d} + {1'b0, step};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [7:0] fc_lower(input logic [7:0] d, input logic [7:0] step,
                                          input logic [7:0] floor);
    logic [8:0] lim;
    lim = {1'b0, floor} + {1'b0, step};
    return ({1'b0, d} < lim) ? floor : (d - step);
  endfunction

  function automatic logic [7:0] fc_max8(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fanctl_tach_meter.sv
module fanctl_tach_meter #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tach_in,
  output logic [CNT_W-1:0] meas,
  output logic             stalled
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N:0]    sync_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], tach_in};
  end

  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      meas  <= CNT_MAX;
    end else if (rise) begin
      meas  <= cnt_q;
      cnt_q <= tick ? CNT_W'(1) : '0;
    end else begin
      if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_MAX)         meas  <= CNT_MAX;
    end
  end

  assign stalled = (meas == CNT_MAX);

endmodule

// File: rtl/fanctl_regs.sv
module fanctl_regs
  import fanctl_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter logic [7:0]       STEP_DEF  = 8'h10,
  parameter logic [7:0]       FLOOR_DEF = 8'h40,
  parameter logic [CNT_W-1:0] VALID_DEF = {1'b0, {(CNT_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [CNT_W-1:0] meas,
  input  logic             stalled,
  input  logic             spin_fail,
  input  logic [7:0]       drive,
  output fan_cfg_t         cfg,
  output logic [7:0]       manual_drv,
  output logic [7:0]       step_lim,
  output logic [7:0]       min_drv,
  output logic [CNT_W-1:0] valid_cnt,
  output logic [CNT_W-1:0] target,
  output logic             host_touch
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= fan_cfg_t'(CFG_RESET);
      manual_drv <= '0;
      step_lim   <= STEP_DEF;
      min_drv    <= FLOOR_DEF;
      valid_cnt  <= VALID_DEF;
      target     <= {CNT_W{1'b1}};
      host_touch <= 1'b0;
    end else begin
      host_touch <= wr_en && (wr_addr == A_CFG || wr_addr == A_TARGET);
      if (wr_en) begin
        case (wr_addr)
          A_CFG:    cfg        <= fan_cfg_t'(wr_data[6:0]);
          A_MANUAL: manual_drv <= wr_data[7:0];
          A_STEP:   step_lim   <= wr_data[7:0];
          A_FLOOR:  min_drv    <= wr_data[7:0];
          A_VALID:  valid_cnt  <= wr_data;
          A_TARGET: target     <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:    rd_data = CNT_W'(cfg);
      A_MANUAL: rd_data = CNT_W'(manual_drv);
      A_STEP:   rd_data = CNT_W'(step_lim);
      A_FLOOR:  rd_data = CNT_W'(min_drv);
      A_VALID:  rd_data = valid_cnt;
      A_TARGET: rd_data = target;
      A_MEAS:   rd_data = meas;
      default:  rd_data = CNT_W'({spin_fail, stalled, drive});
    endcase
  end

endmodule

// File: rtl/fanctl_sequencer.sv
module fanctl_sequencer
  import fanctl_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int TICKS_PER_MS = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  fan_cfg_t         cfg,
  input  logic             host_touch,
  input  logic [7:0]       manual_drv,
  input  logic [7:0]       step_lim,
  input  logic [7:0]       min_drv,
  input  logic [CNT_W-1:0] valid_cnt,
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] meas,
  input  logic             stalled,
  input  logic [1:0]       boot_sel,
  output logic [7:0]       drive,
  output logic             spin_fail,
  output fan_state_e       state,
  output logic             upd_evt
);
  localparam int TMR_W = $clog2(2000 * TICKS_PER_MS + 1);

  fan_state_e       st_n;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] spin_len, full_len, hold_len, upd_len, cur_len;
  logic             counting, hit, spin_eval, spin_bad;
  logic [7:0]       adj, drive_n;

  assign spin_len = TMR_W'(32'(fc_spin_ms(cfg.spin_sel)) * TICKS_PER_MS);
  assign full_len = spin_len >> 2;
  assign hold_len = spin_len - full_len;
  assign upd_len  = TMR_W'(32'(fc_update_ms(cfg.upd_sel)) * TICKS_PER_MS);

  always_comb begin
    case (state)
      FS_SPIN_FULL: cur_len = full_len;
      FS_SPIN_HOLD: cur_len = hold_len;
      default:      cur_len = upd_len;
    endcase
  end

  assign counting  = (state == FS_SPIN_FULL) || (state == FS_SPIN_HOLD) || (state == FS_RUN);
  assign hit       = counting && tick && (tmr_q >= cur_len - 1'b1);
  assign upd_evt   = (state == FS_RUN) && cfg.en && hit;
  assign spin_eval = (state == FS_SPIN_HOLD) && cfg.en && hit;
  assign spin_bad  = meas > valid_cnt;

  always_comb begin
    st_n = state;
    case (state)
      FS_BOOT:      if (host_touch) st_n = cfg.en ? FS_SPIN_FULL : FS_MANUAL;
      FS_MANUAL:    if (cfg.en) st_n = FS_SPIN_FULL;
      FS_SPIN_FULL: if (!cfg.en) st_n = FS_MANUAL;
                    else if (hit) st_n = FS_SPIN_HOLD;
      FS_SPIN_HOLD: if (!cfg.en) st_n = FS_MANUAL;
                    else if (hit) st_n = spin_bad ? FS_SPIN_FULL : FS_RUN;
      FS_RUN:       if (!cfg.en) st_n = FS_MANUAL;
                    else if (upd_evt && stalled) st_n = FS_SPIN_FULL;
      default:      st_n = FS_BOOT;
    endcase
  end

  always_comb begin
    if (meas > target)      adj = fc_raise(drive, step_lim);
    else if (meas < target) adj = fc_lower(drive, step_lim, min_drv);
    else                    adj = drive;
  end

  always_comb begin
    case (state)
      FS_BOOT:      drive_n = fc_boot_level(boot_sel);
      FS_MANUAL:    drive_n = manual_drv;
      FS_SPIN_FULL: drive_n = 8'hFF;
      FS_SPIN_HOLD: drive_n = fc_hold_level(cfg.hold_hi);
      FS_RUN:       drive_n = (upd_evt && !stalled) ? fc_max8(adj, min_drv)
                                                    : fc_max8(drive, min_drv);
      default:      drive_n = drive;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_BOOT;
      tmr_q     <= '0;
      drive     <= '0;
      spin_fail <= 1'b0;
    end else begin
      state <= st_n;
      drive <= drive_n;
      if (st_n != state)         tmr_q <= '0;
      else if (counting && tick) tmr_q <= hit ? '0 : tmr_q + 1'b1;
      if (spin_eval) spin_fail <= spin_bad;
    end
  end

endmodule

// File: rtl/fan_speed_ctl.sv
module fan_speed_ctl
  import fanctl_pkg::*;
#(
  parameter int               CNT_W        = 16,
  parameter int               TICKS_PER_MS = 33,
  parameter logic [7:0]       STEP_DEF     = 8'h10,
  parameter logic [7:0]       FLOOR_DEF    = 8'h40,
  parameter logic [CNT_W-1:0] VALID_DEF    = {1'b0, {(CNT_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tick_32k,
  input  logic             tach_in,
  input  logic [1:0]       boot_sel,
  output logic [7:0]       drive,
  output logic             stalled,
  output logic             spin_fail
);
  // CNT_W must be at least 10 so the status word fits the read port.

  fan_cfg_t         cfg;
  logic [7:0]       manual_drv, step_lim, min_drv;
  logic [CNT_W-1:0] valid_cnt, target, meas;
  logic             host_touch, upd_evt;
  fan_state_e       state;

  logic in_boot, in_manual, in_spin_full, in_run;
  assign in_boot      = (state == FS_BOOT);
  assign in_manual    = (state == FS_MANUAL);
  assign in_spin_full = (state == FS_SPIN_FULL);
  assign in_run       = (state == FS_RUN);

  fanctl_tach_meter #(.CNT_W(CNT_W), .SYNC_N(2)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_32k),
    .tach_in (tach_in),
    .meas    (meas),
    .stalled (stalled)
  );

  fanctl_regs #(
    .CNT_W(CNT_W), .STEP_DEF(STEP_DEF), .FLOOR_DEF(FLOOR_DEF), .VALID_DEF(VALID_DEF)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .meas       (meas),
    .stalled    (stalled),
    .spin_fail  (spin_fail),
    .drive      (drive),
    .cfg        (cfg),
    .manual_drv (manual_drv),
    .step_lim   (step_lim),
    .min_drv    (min_drv),
    .valid_cnt  (valid_cnt),
    .target     (target),
    .host_touch (host_touch)
  );

  fanctl_sequencer #(.CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_32k),
    .cfg        (cfg),
    .host_touch (host_touch),
    .manual_drv (manual_drv),
    .step_lim   (step_lim),
    .min_drv    (min_drv),
    .valid_cnt  (valid_cnt),
    .target     (target),
    .meas       (meas),
    .stalled    (stalled),
    .boot_sel   (boot_sel),
    .drive      (drive),
    .spin_fail  (spin_fail),
    .state      (state),
    .upd_evt    (upd_evt)
  );

endmodule

// File: rtl/fanctl_checker.sv
module fanctl_checker
  import fanctl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_boot,
  input logic       in_manual,
  input logic       in_spin_full,
  input logic       in_run,
  input logic       upd_evt,
  input logic       stalled,
  input logic [7:0] drive,
  input logic [7:0] manual_drv,
  input logic [7:0] min_drv,
  input logic [7:0] step_lim,
  input logic [1:0] boot_sel
);
  logic [1:0] warm;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (!warm[1])   warm <= warm + 1'b1;
  end
  assign armed = warm[1];

  AST_BOOT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_boot)) |-> drive == fc_boot_level($past(boot_sel))); // R1

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_manual)) |-> drive == $past(manual_drv)); // R2

  AST_SPIN_FULL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_spin_full)) |-> drive == 8'hFF); // R5

  AST_STEP_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_run) && drive > $past(drive) && drive != $past(min_drv))
      |-> (int'(drive) - int'($past(drive))) <= int'($past(step_lim))); // R8

  AST_STEP_DN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_run) && drive < $past(drive))
      |-> (int'($past(drive)) - int'(drive)) <= int'($past(step_lim))); // R8

  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_run)) |-> drive >= $past(min_drv)); // R9

  AST_STALL_RESPIN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && stalled) |=> in_spin_full); // R10

endmodule

bind fan_speed_ctl fanctl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_boot      (in_boot),
  .in_manual    (in_manual),
  .in_spin_full (in_spin_full),
  .in_run       (in_run),
  .upd_evt      (upd_evt),
  .stalled      (stalled),
  .drive        (drive),
  .manual_drv   (manual_drv),
  .min_drv      (min_drv),
  .step_lim     (step_lim),
  .boot_sel     (boot_sel)
);

// File: tb/sim_fan_speed_ctl.sv
module sim_fan_speed_ctl;
  localparam int W = 10;
  localparam int CMAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         tick_32k = 1'b1;
  logic         tach_in = 1'b0;
  logic [1:0]   boot_sel = 2'b01;
  logic [7:0]   drive;
  logic         stalled, spin_fail;

  int checks = 0;
  int errors = 0;
  int tach_per = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fan_speed_ctl #(.CNT_W(W), .TICKS_PER_MS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_32k(tick_32k), .tach_in(tach_in),
    .boot_sel(boot_sel), .drive(drive), .stalled(stalled), .spin_fail(spin_fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_chg(input int lim, output int n);
    logic [7:0] p;
    p = drive;
    n = 0;
    while (drive == p && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0;
    boot_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int mkcfg(input int hold_hi, input int spin, input int upd, input int en);
    return (hold_hi << 6) | (spin << 4) | (upd << 1) | en;
  endfunction

  // tach generator: one period every tach_per cycles, idle low when 0
  initial begin
    forever begin
      if (tach_per == 0) begin
        tach_in = 1'b0;
        @(negedge clk);
      end else begin
        tach_in = 1'b1;
        repeat (tach_per / 2) @(negedge clk);
        tach_in = 1'b0;
        repeat (tach_per - tach_per / 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n, d, e;

    // R1: strap level out of reset
    do_reset(2'b01);
    chk("R1 boot level sel 01", int'(drive), 128);
    do_reset(2'b10);
    chk("R1 boot level sel 10", int'(drive), 191);
    // R4: count starts saturated
    rd(3'd6, v);
    chk("R4 count after reset", v, CMAX);
    chk("R4 stalled after reset", int'(stalled), 1);

    wr(3'd2, 16);
    wr(3'd3, 64);
    wr(3'd4, 500);
    wr(3'd1, 8'hC3);
    repeat (5) @(negedge clk);
    chk("R1 other writes keep strap level", int'(drive), 191);

    // R2: manual mode
    wr(3'd0, mkcfg(0, 1, 3, 0));
    repeat (4) @(negedge clk);
    chk("R2 manual drive C3", int'(drive), 8'hC3);
    wr(3'd1, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R2 manual drive 5A", int'(drive), 8'h5A);
    rd(3'd7, v);
    chk("R2 status drive field", v & 8'hFF, 8'h5A);
    wr(3'd1, 8'hC3);

    // R3: period measurement
    tach_per = 50;
    repeat (200) @(negedge clk);
    rd(3'd6, v);
    chk("R3 period 50", v, 50);
    chk("R4 not stalled with tach", int'(stalled), 0);
    tach_per = 137;
    repeat (450) @(negedge clk);
    rd(3'd6, v);
    chk("R3 period 137", v, 137);
    tach_per = 50;
    repeat (200) @(negedge clk);

    // R5/R6/R7/R8: start loop, spin 250 ms, update 100 ms, target below count
    wr(3'd5, 20);
    wr(3'd0, mkcfg(0, 0, 0, 1));
    wait_chg(20, n);
    chk("R5 spin-up starts at full", int'(drive), 255);
    wait_chg(200, n);
    chk("R5 hold level 60 percent", int'(drive), 153);
    chk("R5 full phase length 250/4", n, 62);
    d = 153;
    for (int i = 0; d != 255; i++) begin
      e = (d + 16 > 255) ? 255 : d + 16;
      wait_chg(500, n);
      chk("R8 raise by step", int'(drive), e);
      if (i == 0) chk("R6 spin-up passed", int'(spin_fail), 0);
      else        chk("R7 update interval 100", n, 100);
      d = e;
    end
    wait_chg(250, n);
    chk("R8 clamp at 255 holds", int'(drive), 255);

    // R8/R9: target above count, lower down to floor
    wr(3'd5, 1000);
    d = 255;
    while (d != 64) begin
      e = (d < 64 + 16) ? 64 : d - 16;
      wait_chg(300, n);
      chk("R8 lower by step", int'(drive), e);
      d = e;
    end
    wait_chg(250, n);
    chk("R9 floor holds", int'(drive), 64);

    // R7: interval 800 ms
    wr(3'd0, mkcfg(0, 0, 4, 1));
    wr(3'd5, 20);
    wait_chg(900, n);
    chk("R8 raise after interval change", int'(drive), 80);
    wait_chg(900, n);
    chk("R8 raise second", int'(drive), 96);
    chk("R7 update interval 800", n, 800);

    // R10/R6: stall in loop, failed spin-up, retry
    wr(3'd5, 1000);
    wr(3'd0, mkcfg(1, 1, 0, 1));
    repeat (1700) @(negedge clk);
    chk("R9 floor reached", int'(drive), 64);
    tach_per = 0;
    wait_chg(1400, n);
    chk("R10 stall restarts spin-up", int'(drive), 255);
    rd(3'd6, v);
    chk("R4 count saturated", v, CMAX);
    chk("R4 stalled flag", int'(stalled), 1);
    wait_chg(200, n);
    chk("R5 hold level 75 percent", int'(drive), 191);
    chk("R5 full phase length 500/4", n, 125);
    wait_chg(500, n);
    chk("R6 retry at full drive", int'(drive), 255);
    chk("R5 hold phase length", n, 375);
    chk("R6 spin_fail set", int'(spin_fail), 1);
    rd(3'd7, v);
    chk("R2 status spin_fail bit 9", (v >> 9) & 1, 1);
    tach_per = 50;
    wait_chg(200, n);
    chk("R6 retry hold level", int'(drive), 191);
    chk("R6 retry full phase length", n, 125);
    wait_chg(600, n);
    chk("R8 lower after recovered spin-up", int'(drive), 175);
    chk("R6 spin_fail cleared", int'(spin_fail), 0);

    // R2: back to manual
    wr(3'd0, mkcfg(1, 1, 0, 0));
    repeat (3) @(negedge clk);
    chk("R2 manual after loop", int'(drive), 8'hC3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule